// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog counter for a system-control region of a chip. A 32-bit up-counter advances on a slow time-base tick, after an optional power-of-two prescaler. When the counter passes its all-ones value it reloads from a programmable load value, records an overflow status and, if the overflow interrupt is enabled, pulses a watchdog reset output for one clock.

Software can only start or stop the counter with a two-word key sequence written to one register. The load, trigger and key registers reach the timer through a synchronizing path. This path is modelled as a fixed window of time-base ticks. While a write is in flight, its bit in a pending register stays set, and further writes to that register are dropped. Software keeps the watchdog from firing by writing a new value to the trigger register, which reloads the counter.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the revision register (address 0) reads the REVISION parameter. The control register (address 1) reads 0x2. The counter (address 8), the pending register (address 7) and the run state (address 6, bit 0) all read 0.
- R2: When the key register (address 6) is written 0xBBBB and then 0x4444 as its next completed write, the run state becomes 1 and the counter advances by one for each prescaled tick.
- R3: When the key register is written 0xAAAA and then 0x5555 as its next completed write, the run state becomes 0. While the block is stopped, the counter holds its value.
- R4: Any other key pair, a lone second word, or a valid first word followed by an unrelated word leaves the run state unchanged.
- R5: The pending register has bit 0 for load (address 4), bit 1 for trigger (address 5) and bit 2 for key (address 6). Each bit is set by an accepted write and clears on the PEND_TICKS-th tick that follows; the write takes effect on that same tick.
- R6: A write to a synchronized register whose pending bit is set is ignored.
- R7: A completed trigger write whose value differs from the current trigger value reloads the counter from the load value and stores the new trigger value. A write of the same value does not reload.
- R8: When the counter is advanced from 0xFFFFFFFF it reloads from the load value and sets status bit 0 (overflow) at address 3.
- R9: The wdog_rst output is high for exactly one cycle after an overflow, and only if overflow enable bit 0 is set. The irq output is high while any status bit and its enable bit are both set.
- R10: Writing 1s to address 2 sets enable bits (bit 0 overflow, bit 1 delay), and writing 0s there changes nothing. Writing a 1 to a status bit at address 3 clears that bit.
- R11: In the control register, bit 1 enables the prescaler and bits 4:2 hold the exponent P. With bit 1 set the counter advances once every 2^P ticks; with bit 1 clear it advances on every tick.
- R12: Writing 1 to control bit 0 makes it read 1 for one cycle. The block then returns to its reset state, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse of the time-base tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address, also selects the read data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The case that is hardest to reach is a second write landing on a register whose synchronizing window is still open. While the bus stays idle, ticks arriving on every cycle close that window too quickly to hit. The bench therefore stops the tick, writes the load register twice, checks the pending bit, and only then lets ticks resume. Overflow is reached in a few hundred cycles by loading a value just below all-ones, and it is run once with the interrupt enabled and once, after a soft reset, with it masked.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int PTV_W  = 3;
    localparam int NSYNC  = 3;

    localparam logic [ADDR_W-1:0] ADR_REV  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_LOAD = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_TRIG = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_KEY  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_PEND = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 4'd8;

    localparam int SY_LOAD = 0;
    localparam int SY_TRIG = 1;
    localparam int SY_KEY  = 2;

    localparam logic [DATA_W-1:0] KEY_RUN_1  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_RUN_2  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_HALT_1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT_2 = 32'h0000_5555;

    typedef enum logic [1:0] {KS_IDLE, KS_RUN_HALF, KS_HALT_HALF} key_state_e;

    typedef struct packed {
        logic [PTV_W-1:0] ptv;
        logic             pre_en;
        logic             srst;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ptv: '0, pre_en: 1'b1, srst: 1'b0};

    function automatic logic [ADDR_W-1:0] sync_addr(input int idx);
        return ADR_LOAD + ADDR_W'(idx);
    endfunction
endpackage

// File: rtl/kwd_sync_slot.sv
module kwd_sync_slot import kwd_pkg::*; #(
    parameter int PEND_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic [DATA_W-1:0] wdata,
    output logic              pend,
    output logic              apply,
    output logic [DATA_W-1:0] value
);
    localparam int CNT_W = $clog2(PEND_TICKS + 1);

    logic [CNT_W-1:0] left_q;

    assign apply = pend && tick && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            left_q <= '0;
            value  <= '0;
        end else if (!pend && req) begin
            pend   <= 1'b1;
            left_q <= CNT_W'(PEND_TICKS);
            value  <= wdata;
        end else if (pend && tick) begin
            if (left_q == CNT_W'(1)) pend <= 1'b0;
            left_q <= left_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale import kwd_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             strobe
);
    localparam int DIV_W = (2 ** PTV_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask   = ~({DIV_W{1'b1}} << ptv);
    assign strobe = run && tick && (!pre_en || (div_q == mask));

    always_ff @(posedge clk) begin
        if (rst || !run)  div_q <= '0;
        else if (strobe)  div_q <= '0;
        else if (tick)    div_q <= div_q + DIV_W'(1);
    end
endmodule

// File: rtl/kwd_keymatch.sv
module kwd_keymatch import kwd_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  logic [DATA_W-1:0] word,
    output logic              run
);
    key_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KS_IDLE;
            run  <= 1'b0;
        end else if (apply) begin
            if (st_q == KS_RUN_HALF && word == KEY_RUN_2) begin
                run  <= 1'b1;
                st_q <= KS_IDLE;
            end else if (st_q == KS_HALT_HALF && word == KEY_HALT_2) begin
                run  <= 1'b0;
                st_q <= KS_IDLE;
            end else if (word == KEY_RUN_1) begin
                st_q <= KS_RUN_HALF;
            end else if (word == KEY_HALT_1) begin
                st_q <= KS_HALT_HALF;
            end else begin
                st_q <= KS_IDLE;
            end
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog import kwd_pkg::*; #(
    parameter int          PEND_TICKS = 3,
    parameter logic [31:0] REVISION   = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wdog_rst
);
    ctrl_t             ctrl_q;
    logic [1:0]        ien_q, stat_q;
    logic [DATA_W-1:0] load_q, trig_q, cnt_q;
    logic              run_q, strobe, ovf, trig_reload, rst_int;
    logic [NSYNC-1:0]  pend, apply;
    logic [DATA_W-1:0] sync_val [NSYNC];

    assign rst_int = rst || ctrl_q.srst;

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        kwd_sync_slot #(.PEND_TICKS(PEND_TICKS)) u_slot (
            .clk   (clk),
            .rst   (rst_int),
            .tick  (tick_en),
            .req   (wr_en && (addr == sync_addr(g))),
            .wdata (wdata),
            .pend  (pend[g]),
            .apply (apply[g]),
            .value (sync_val[g])
        );
    end

    kwd_keymatch u_key (
        .clk   (clk),
        .rst   (rst_int),
        .apply (apply[SY_KEY]),
        .word  (sync_val[SY_KEY]),
        .run   (run_q)
    );

    kwd_prescale u_pre (
        .clk    (clk),
        .rst    (rst_int),
        .run    (run_q),
        .tick   (tick_en),
        .pre_en (ctrl_q.pre_en),
        .ptv    (ctrl_q.ptv),
        .strobe (strobe)
    );

    assign ovf         = strobe && (&cnt_q);
    assign trig_reload = apply[SY_TRIG] && (sync_val[SY_TRIG] != trig_q);

    always_ff @(posedge clk) begin
        if (rst_int) begin
            ctrl_q   <= CTRL_RESET;
            ien_q    <= '0;
            stat_q   <= '0;
            load_q   <= '0;
            trig_q   <= '0;
            cnt_q    <= '0;
            wdog_rst <= 1'b0;
        end else begin
            if (wr_en && addr == ADR_CTRL) ctrl_q <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
            if (wr_en && addr == ADR_IEN)  ien_q  <= ien_q | wdata[1:0];
            stat_q <= (stat_q & ~((wr_en && addr == ADR_STAT) ? wdata[1:0] : 2'b00))
                      | {1'b0, ovf};
            if (apply[SY_LOAD]) load_q <= sync_val[SY_LOAD];
            if (trig_reload)    trig_q <= sync_val[SY_TRIG];
            if (trig_reload || ovf) cnt_q <= load_q;
            else if (strobe)        cnt_q <= cnt_q + 32'd1;
            wdog_rst <= ovf && ien_q[0];
        end
    end

    assign irq = |(stat_q & ien_q);

    always_comb begin
        case (addr)
            ADR_REV:  rdata = REVISION;
            ADR_CTRL: rdata = {{(DATA_W-$bits(ctrl_t)){1'b0}}, ctrl_q};
            ADR_IEN:  rdata = {30'd0, ien_q};
            ADR_STAT: rdata = {30'd0, stat_q};
            ADR_LOAD: rdata = load_q;
            ADR_TRIG: rdata = trig_q;
            ADR_KEY:  rdata = {31'd0, run_q};
            ADR_PEND: rdata = {{(DATA_W-NSYNC){1'b0}}, pend};
            ADR_CNT:  rdata = cnt_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk import kwd_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              srst,
    input logic              tick_en,
    input logic              run,
    input logic              key_apply,
    input logic              trig_reload,
    input logic [DATA_W-1:0] cnt,
    input logic [NSYNC-1:0]  pend,
    input logic              wdog_rst,
    input logic              stat_ovf
);
    // R9
    wdog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> !wdog_rst);

    // R9
    wdog_stat_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> stat_ovf);

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!key_apply && !srst) |=> $stable(run));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !trig_reload && !srst) |=> $stable(cnt));

    // R12
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        srst |=> !srst);

    for (genvar g = 0; g < NSYNC; g++) begin : g_pend
        // R5
        pend_fall_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(pend[g]) |-> $past(tick_en || srst || rst));
    end
endmodule

bind keyed_wdog kwd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .srst        (ctrl_q.srst),
    .tick_en     (tick_en),
    .run         (run_q),
    .key_apply   (apply[SY_KEY]),
    .trig_reload (trig_reload),
    .cnt         (cnt_q),
    .pend        (pend),
    .wdog_rst    (wdog_rst),
    .stat_ovf    (stat_q[0])
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
    localparam int PT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq, wdog_rst;

    int errs = 0, checks = 0, tick_per = 1, tcnt = 0, pulses = 0;
    logic [31:0] d, c1, c2;

    always #2 clk = ~clk;

    keyed_wdog #(.PEND_TICKS(PT)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic        m_run, m_pre, m_srst, m_wdog;
    logic [2:0]  m_ptv, m_pend;
    logic [1:0]  m_ien, m_stat;
    logic [31:0] m_cnt, m_load, m_trig;
    logic [31:0] m_stg [3];
    int          m_pc [3];
    int          m_pcnt, m_kst;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return 32'h0001_0203;
            4'd1: return {27'd0, m_ptv, m_pre, m_srst};
            4'd2: return {30'd0, m_ien};
            4'd3: return {30'd0, m_stat};
            4'd4: return m_load;
            4'd5: return m_trig;
            4'd6: return {31'd0, m_run};
            4'd7: return {29'd0, m_pend};
            4'd8: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [2:0] ap, acc;
        logic strobe, ovf, reload;
        if (rst || m_srst) begin
            m_run = 0; m_pre = 1; m_srst = 0; m_wdog = 0; m_ptv = 0; m_pend = 0;
            m_ien = 0; m_stat = 0; m_cnt = 0; m_load = 0; m_trig = 0;
            m_pcnt = 0; m_kst = 0;
            for (int i = 0; i < 3; i++) begin m_stg[i] = 0; m_pc[i] = 0; end
        end else begin
            for (int i = 0; i < 3; i++) begin
                ap[i]  = m_pend[i] && tick_en && (m_pc[i] == 1);
                acc[i] = wr_en && (addr == 4'(4 + i)) && !m_pend[i];
            end
            strobe = m_run && tick_en && (!m_pre || m_pcnt == ((1 << m_ptv) - 1));
            ovf    = strobe && (m_cnt == 32'hFFFF_FFFF);
            reload = ap[1] && (m_stg[1] != m_trig);
            m_wdog = ovf && m_ien[0];
            if (reload || ovf) m_cnt = m_load;
            else if (strobe) m_cnt = m_cnt + 1;
            if (!m_run) m_pcnt = 0;
            else if (tick_en) m_pcnt = strobe ? 0 : (m_pcnt + 1) % 128;
            if (reload) m_trig = m_stg[1];
            if (ap[0]) m_load = m_stg[0];
            if (ap[2]) begin
                if (m_kst == 1 && m_stg[2] == 32'h4444) begin m_run = 1; m_kst = 0; end
                else if (m_kst == 2 && m_stg[2] == 32'h5555) begin m_run = 0; m_kst = 0; end
                else if (m_stg[2] == 32'hBBBB) m_kst = 1;
                else if (m_stg[2] == 32'hAAAA) m_kst = 2;
                else m_kst = 0;
            end
            if (wr_en && addr == 4'd3) m_stat = m_stat & ~wdata[1:0];
            if (ovf) m_stat[0] = 1'b1;
            if (wr_en && addr == 4'd2) m_ien = m_ien | wdata[1:0];
            if (wr_en && addr == 4'd1) begin
                m_srst = wdata[0]; m_pre = wdata[1]; m_ptv = wdata[4:2];
            end
            for (int i = 0; i < 3; i++) begin
                if (ap[i]) m_pend[i] = 1'b0;
                else if (m_pend[i] && tick_en) m_pc[i] = m_pc[i] - 1;
                if (acc[i]) begin m_stg[i] = wdata; m_pc[i] = PT; m_pend[i] = 1'b1; end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        tcnt++;
        tick_en = (tick_per > 0) && (tcnt % (tick_per > 0 ? tick_per : 1) == 0);
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 rdata vs model", rdata, m_read(addr));
            chk("R9 irq vs model", {31'd0, irq}, {31'd0, |(m_stat & m_ien)});
            chk("R9 wdog_rst vs model", {31'd0, wdog_rst}, {31'd0, m_wdog});
            if (wdog_rst) pulses++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(posedge clk); #1; wr_en = 1; addr = a; wdata = v;
        @(posedge clk); #1; wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1; wr_en = 0; addr = a;
        @(negedge clk); v = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic key(input logic [31:0] v);
        wr(4'd6, v); wait_cyc(6);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cyc(3); #1; rst = 0;
        // R1 reset state
        rd(4'd0, d); chk("R1 revision", d, 32'h0001_0203);
        rd(4'd1, d); chk("R1 control", d, 32'h2);
        rd(4'd8, d); chk("R1 counter", d, 32'h0);
        rd(4'd7, d); chk("R1 pending", d, 32'h0);
        rd(4'd6, d); chk("R1 run", d, 32'h0);
        // R5 / R6: freeze the tick so the window stays open
        tick_per = 0; wait_cyc(2);
        wr(4'd4, 32'hFFFF_FF00);
        wr(4'd4, 32'h0000_1111);
        rd(4'd7, d); chk("R5 load pending", d, 32'h1);
        tick_per = 1; wait_cyc(6);
        rd(4'd7, d); chk("R5 pending cleared", d, 32'h0);
        rd(4'd4, d); chk("R6 second write ignored", d, 32'hFFFF_FF00);
        // R7 trigger reload
        wr(4'd5, 32'h1); wait_cyc(6);
        rd(4'd8, d); chk("R7 reload on new trigger", d, 32'hFFFF_FF00);
        // R2 start
        key(32'hBBBB); key(32'h4444);
        rd(4'd6, d); chk("R2 running", d, 32'h1);
        rd(4'd8, c1); rd(4'd8, c2); chk("R2 advances", c2 - c1, 32'h1);
        // R8 / R9 overflow with enable
        wr(4'd2, 32'h1);
        pulses = 0;
        for (int k = 0; k < 400 && pulses == 0; k++) @(posedge clk);
        wait_cyc(2);
        chk("R9 one pulse", pulses, 1);
        rd(4'd3, d); chk("R8 overflow status", d, 32'h1);
        chk("R9 irq high", {31'd0, irq}, 32'h1);
        rd(4'd8, d); chk("R8 reloaded", {31'd0, (d >= 32'hFFFF_FF00) && (d < 32'hFFFF_FF10)}, 32'h1);
        // R10 W1C and enable set
        wr(4'd3, 32'h1);
        rd(4'd3, d); chk("R10 status cleared", d, 32'h0);
        chk("R10 irq low", {31'd0, irq}, 32'h0);
        wr(4'd2, 32'h2); rd(4'd2, d); chk("R10 enables accumulate", d, 32'h3);
        wr(4'd2, 32'h0); rd(4'd2, d); chk("R10 zero write no effect", d, 32'h3);
        // R3 stop
        key(32'hAAAA); key(32'h5555);
        rd(4'd6, d); chk("R3 stopped", d, 32'h0);
        rd(4'd8, c1); wait_cyc(10); rd(4'd8, c2); chk("R3 counter holds", c2, c1);
        // R4 malformed sequences
        key(32'hBBBB); key(32'h5555);
        rd(4'd6, d); chk("R4 mismatched pair", d, 32'h0);
        key(32'h4444);
        rd(4'd6, d); chk("R4 lone second word", d, 32'h0);
        key(32'hBBBB); key(32'h1234); key(32'h4444);
        rd(4'd6, d); chk("R4 interrupted pair", d, 32'h0);
        // R7 same value does not reload
        wr(4'd4, 32'h1234_5678); wait_cyc(6);
        wr(4'd5, 32'h1); wait_cyc(6);
        rd(4'd8, d); chk("R7 same trigger no reload", d, c2);
        wr(4'd5, 32'h7); wait_cyc(6);
        rd(4'd8, d); chk("R7 new trigger reloads", d, 32'h1234_5678);
        // R11 prescaler
        wr(4'd1, 32'hA);
        rd(4'd1, d); chk("R11 control readback", d, 32'hA);
        key(32'hBBBB); key(32'h4444);
        rd(4'd8, c1); wait_cyc(15); rd(4'd8, c2);
        chk("R11 divide by 4", c2 - c1, 32'h4);
        wr(4'd1, 32'h8);
        rd(4'd8, c1); wait_cyc(15); rd(4'd8, c2);
        chk("R11 prescaler off", c2 - c1, 32'h10);
        // R12 soft reset
        @(posedge clk); #1; wr_en = 1; addr = 4'd1; wdata = 32'h1;
        @(posedge clk); #1; wr_en = 0;
        @(negedge clk); chk("R12 bit reads set", rdata, 32'h1);
        rd(4'd1, d); chk("R12 control reset", d, 32'h2);
        rd(4'd6, d); chk("R12 stopped", d, 32'h0);
        rd(4'd2, d); chk("R12 enables cleared", d, 32'h0);
        rd(4'd8, d); chk("R12 counter cleared", d, 32'h0);
        // R9 masked overflow
        wr(4'd4, 32'hFFFF_FFF0); wait_cyc(6);
        wr(4'd5, 32'h5); wait_cyc(6);
        pulses = 0;
        key(32'hBBBB); key(32'h4444);
        wait_cyc(40);
        chk("R9 masked no pulse", pulses, 0);
        rd(4'd3, d); chk("R8 status without enable", d, 32'h1);
        chk("R9 irq masked", {31'd0, irq}, 32'h0);
        finish_run();
    end
endmodule